// File: doc/BRIEF.md
# 32-Pin General-Purpose I/O Bank with Self-Clearing Soft Reset

This block is one bank of general-purpose pins behind a small word-addressed register port. Software picks, per pin, whether the bank drives the pin or only samples it, sets the level driven, and reads back the pin levels after a two-flop synchroniser. Any pin can also act as an interrupt source. Each pin has four detect enables: rising edge, falling edge, high level and low level. Each of the two interrupt lines has its own per-pin mask and its own sticky status register, and software clears status bits by writing ones to them.

A control register holds a soft-reset command bit and a reset-done flag. Writing 1 to the command bit returns every configuration and status register to its power-on value. The bank then ignores register writes for a fixed number of cycles, and the done flag is low for that window. The command bit clears itself, so it always reads 0. Reads are combinational, and a write takes effect on the clock edge where `bus_wr` is high.

Top module: `gpio_bank`

## Requirements
- R1: After `rst_n` is released, no pin is driven (`gpio_drive` = 0, direction register at word 1 = all ones), `gpio_out` = 0, all enable, mask and status registers read 0, `irq` = 0, and the control word (word 0) reads 2 (bit 1 = done, bit 0 = 0).
- R2: In the direction register (word 1), bit value 0 makes the pin an output, so `gpio_drive` bit = 1. Bit value 1 makes it an input, so `gpio_drive` bit = 0. The register reads back as written.
- R3: The output register (word 2) reads back as written, and `gpio_out` follows it one edge after the write. `gpio_out` changes only on a register write.
- R4: The input register (word 3) returns `gpio_in` after two clock edges. A change is not visible after one edge and is visible after the second edge.
- R5: Writing 1 to control bit 0 returns words 1, 2, 4 to 11 to their R1 values. Control bit 0 always reads 0, and writing 0 to it changes nothing.
- R6: After a soft reset the done bit (control bit 1) reads 0 for exactly RST_CYCLES (default 4) cycles and then reads 1. Register writes during that window are ignored.
- R7: The rising-edge enables (word 4) and falling-edge enables (word 5) set status one edge after the synchronised level changes in the enabled direction. A change in a direction that is not enabled sets nothing.
- R8: The high-level enables (word 6) and low-level enables (word 7) set status on every cycle in which the synchronised pin sits at the enabled level.
- R9: An event sets bit n of status line k (word 10+k) only when bit n of mask k (word 8+k) is 1, and `irq[k]` is the OR of status line k.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W (4) | Register word index |
| bus_wdata | input | NUM_PINS (32) | Write data |
| bus_rdata | output | NUM_PINS (32) | Combinational read data for `bus_addr` |
| gpio_in | input | NUM_PINS (32) | Pin levels from the pads, asynchronous |
| gpio_out | output | NUM_PINS (32) | Levels to drive |
| gpio_drive | output | NUM_PINS (32) | 1 = pad driven by the bank |
| irq | output | NUM_IRQ (2) | Interrupt lines, level high |

## Verification
The hardest case to reach from the ports is a clear and an event in the same cycle. A status write lands exactly when a detected event is true only if the pin state, the enables and the write edge line up. The stimulus produces this case by holding a pin at a level-enabled value while it writes ones to the status register, so the event is active on the very edge of the clear. Random runs hold a pin value long enough to settle, clear the status, and then move to a second value. Each expected status word is then fixed by both pin values and the enables. The soft-reset window is probed cycle by cycle by reading the done bit, with a write placed inside the window.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    // register word indices
    localparam int ADR_CTRL  = 0;
    localparam int ADR_DIR   = 1;
    localparam int ADR_DOUT  = 2;
    localparam int ADR_DIN   = 3;
    localparam int ADR_RISE  = 4;
    localparam int ADR_FALL  = 5;
    localparam int ADR_HI    = 6;
    localparam int ADR_LO    = 7;
    localparam int ADR_MASK0 = 8;   // one mask word per line, then one status word per line
    localparam int CTRL_SRST_BIT = 0;
    localparam int CTRL_DONE_BIT = 1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = pin_i;
        sy_d.s2 = sy_q.s1;
        sy_d.s3 = sy_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign level_o = sy_q.s2;
    assign rise_o  = sy_q.s2 & ~sy_q.s3;
    assign fall_o  = ~sy_q.s2 & sy_q.s3;
endmodule

// File: rtl/gpio_irq_line.sv
module gpio_irq_line #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] event_i,
    input  logic [W-1:0] mask_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] clr_data_i,
    input  logic         flush_i,
    output logic [W-1:0] stat_o,
    output logic         irq_o
);
    logic [W-1:0] stat_d, stat_q;

    always_comb begin
        if (flush_i) begin
            stat_d = '0;
        end else begin
            stat_d = stat_q & ~(clr_we_i ? clr_data_i : '0);
            stat_d = stat_d | (event_i & mask_i);   // set wins over clear
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat_o = stat_q;
    assign irq_o  = |stat_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS   = 32,
    parameter int NUM_IRQ    = 2,
    parameter int RST_CYCLES = 4,
    parameter int ADDR_W     = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0] gpio_in,
    output logic [NUM_PINS-1:0] gpio_out,
    output logic [NUM_PINS-1:0] gpio_drive,
    output logic [NUM_IRQ-1:0]  irq
);
    localparam int CNT_W     = $clog2(RST_CYCLES + 1);
    localparam int STAT_BASE = ADR_MASK0 + NUM_IRQ;

    typedef struct packed {
        logic [NUM_PINS-1:0]              oe_n;
        logic [NUM_PINS-1:0]              dout;
        logic [NUM_PINS-1:0]              rise_en;
        logic [NUM_PINS-1:0]              fall_en;
        logic [NUM_PINS-1:0]              hi_en;
        logic [NUM_PINS-1:0]              lo_en;
        logic [NUM_IRQ-1:0][NUM_PINS-1:0] mask;
        logic [CNT_W-1:0]                 cnt;
    } state_t;

    state_t st_d, st_q, st_rst;

    logic [NUM_PINS-1:0] lvl, rise, fall, evt;
    logic [NUM_IRQ-1:0][NUM_PINS-1:0] stat;
    logic [NUM_IRQ-1:0] clr_we;
    logic srst_busy, srst_start, flush;

    gpio_sync #(.W(NUM_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(gpio_in),
        .level_o(lvl), .rise_o(rise), .fall_o(fall)
    );

    always_comb begin
        st_rst      = '0;
        st_rst.oe_n = '1;
    end

    assign srst_busy  = (st_q.cnt != '0);
    assign srst_start = !srst_busy && bus_wr && (bus_addr == ADDR_W'(ADR_CTRL))
                        && bus_wdata[CTRL_SRST_BIT];
    assign flush      = srst_busy || srst_start;

    assign evt = (rise & st_q.rise_en) | (fall & st_q.fall_en)
               | (lvl & st_q.hi_en) | (~lvl & st_q.lo_en);

    always_comb begin
        st_d = st_q;
        if (srst_busy) begin
            st_d     = st_rst;
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end else if (srst_start) begin
            st_d     = st_rst;
            st_d.cnt = CNT_W'(RST_CYCLES);
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(ADR_DIR))  st_d.oe_n    = bus_wdata;
            if (bus_addr == ADDR_W'(ADR_DOUT)) st_d.dout    = bus_wdata;
            if (bus_addr == ADDR_W'(ADR_RISE)) st_d.rise_en = bus_wdata;
            if (bus_addr == ADDR_W'(ADR_FALL)) st_d.fall_en = bus_wdata;
            if (bus_addr == ADDR_W'(ADR_HI))   st_d.hi_en   = bus_wdata;
            if (bus_addr == ADDR_W'(ADR_LO))   st_d.lo_en   = bus_wdata;
            for (int k = 0; k < NUM_IRQ; k++) begin
                if (bus_addr == ADDR_W'(ADR_MASK0 + k)) st_d.mask[k] = bus_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= st_rst;
        else        st_q <= st_d;
    end

    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_line
        assign clr_we[k] = bus_wr && !srst_busy && (bus_addr == ADDR_W'(STAT_BASE + k));
        gpio_irq_line #(.W(NUM_PINS)) u_line (
            .clk(clk), .rst_n(rst_n), .event_i(evt), .mask_i(st_q.mask[k]),
            .clr_we_i(clr_we[k]), .clr_data_i(bus_wdata), .flush_i(flush),
            .stat_o(stat[k]), .irq_o(irq[k])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(ADR_CTRL)) bus_rdata[CTRL_DONE_BIT] = !srst_busy;
        if (bus_addr == ADDR_W'(ADR_DIR))  bus_rdata = st_q.oe_n;
        if (bus_addr == ADDR_W'(ADR_DOUT)) bus_rdata = st_q.dout;
        if (bus_addr == ADDR_W'(ADR_DIN))  bus_rdata = lvl;
        if (bus_addr == ADDR_W'(ADR_RISE)) bus_rdata = st_q.rise_en;
        if (bus_addr == ADDR_W'(ADR_FALL)) bus_rdata = st_q.fall_en;
        if (bus_addr == ADDR_W'(ADR_HI))   bus_rdata = st_q.hi_en;
        if (bus_addr == ADDR_W'(ADR_LO))   bus_rdata = st_q.lo_en;
        for (int k = 0; k < NUM_IRQ; k++) begin
            if (bus_addr == ADDR_W'(ADR_MASK0 + k)) bus_rdata = st_q.mask[k];
            if (bus_addr == ADDR_W'(STAT_BASE + k)) bus_rdata = stat[k];
        end
    end

    assign gpio_out   = st_q.dout;
    assign gpio_drive = ~st_q.oe_n;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int NUM_IRQ  = 2,
    parameter int ADDR_W   = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [NUM_PINS-1:0] bus_wdata,
    input logic [NUM_PINS-1:0] bus_rdata,
    input logic [NUM_PINS-1:0] gpio_in,
    input logic [NUM_PINS-1:0] gpio_out,
    input logic [NUM_PINS-1:0] gpio_drive,
    input logic [NUM_IRQ-1:0]  irq,
    input logic                srst_busy
);
    logic [1:0] age_q;
    logic       srst_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    assign srst_req = bus_wr && (bus_addr == ADDR_W'(ADR_CTRL)) && bus_wdata[CTRL_SRST_BIT];

    AST_SRST_BIT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(ADR_CTRL)) |-> !bus_rdata[CTRL_SRST_BIT]); // R5

    AST_SRST_CLEARS_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_req && !srst_busy) |=> (gpio_drive == '0 && gpio_out == '0 && irq == '0)); // R5

    AST_DONE_LOW_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_busy && bus_addr == ADDR_W'(ADR_CTRL)) |-> !bus_rdata[CTRL_DONE_BIT]); // R6

    AST_BUSY_IGNORES_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        srst_busy |=> ($stable(gpio_drive) && $stable(gpio_out))); // R6

    AST_OUT_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(gpio_out)); // R3

    AST_DIN_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && bus_addr == ADDR_W'(ADR_DIN)) |-> (bus_rdata == $past(gpio_in, 2))); // R4
endmodule

bind gpio_bank gpio_bank_chk #(.NUM_PINS(NUM_PINS), .NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_drive(gpio_drive),
    .irq(irq), .srst_busy(srst_busy)
);

// File: tb/test_gpio_bank.sv
`timescale 1ns/1ps
module test_gpio_bank;
    localparam int A_CTRL = 0, A_DIR = 1, A_DOUT = 2, A_DIN = 3, A_RISE = 4, A_FALL = 5;
    localparam int A_HI = 6, A_LO = 7, A_MASK0 = 8, A_MASK1 = 9, A_STAT0 = 10, A_STAT1 = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] gpio_in = '0;
    logic [31:0] gpio_out, gpio_drive;
    logic [1:0]  irq;
    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;   // 50 MHz

    gpio_bank i_gpio_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpio_in(gpio_in),
        .gpio_out(gpio_out), .gpio_drive(gpio_drive), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = 4'(a);
        #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] exp_stat(logic [31:0] a, logic [31:0] b, logic [31:0] re,
            logic [31:0] fe, logic [31:0] he, logic [31:0] le, logic [31:0] m);
        return ((b & ~a & re) | (a & ~b & fe) | ((a | b) & he) | ((~a | ~b) & le)) & m;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, s0, s1;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 drive", gpio_drive, '0);
        chk("R1 out", gpio_out, '0);
        chk("R1 irq", {30'd0, irq}, '0);
        rd(A_CTRL, v);  chk("R1 ctrl", v, 32'd2);
        rd(A_DIR, v);   chk("R1 dir", v, '1);
        for (int a = A_RISE; a <= A_STAT1; a++) begin
            rd(a, v); chk("R1 cfg/stat", v, '0);
        end

        // R2 / R3 directed and random
        wr(A_DIR, 32'hFFFF_0000);
        chk("R2 drive", gpio_drive, 32'h0000_FFFF);
        rd(A_DIR, v); chk("R2 readback", v, 32'hFFFF_0000);
        for (int i = 0; i < 20; i++) begin
            logic [31:0] dr, dt;
            dr = $urandom; dt = $urandom;
            wr(A_DIR, dr);
            wr(A_DOUT, dt);
            chk("R2 drive rnd", gpio_drive, ~dr);
            chk("R3 out rnd", gpio_out, dt);
            rd(A_DOUT, v); chk("R3 readback", v, dt);
        end

        // R4 synchroniser latency
        for (int i = 0; i < 20; i++) begin
            logic [31:0] old_v, new_v;
            old_v = $urandom; new_v = ~old_v;
            @(negedge clk); gpio_in = old_v;
            repeat (3) @(negedge clk);
            gpio_in = new_v;
            @(negedge clk); rd(A_DIN, v); chk("R4 one edge", v, old_v);
            @(negedge clk); rd(A_DIN, v); chk("R4 two edges", v, new_v);
        end

        // R7 / R9 rising edge on pin 3, line 0 only
        @(negedge clk); gpio_in = '0;
        repeat (4) @(negedge clk);
        wr(A_RISE, 32'h8);
        wr(A_MASK0, 32'h8);
        wr(A_STAT0, '1); wr(A_STAT1, '1);
        gpio_in = 32'h8;
        @(negedge clk); @(negedge clk);
        rd(A_STAT0, v); chk("R7 not yet", v, '0);
        @(negedge clk);
        rd(A_STAT0, v); chk("R7 rise set", v, 32'h8);
        chk("R9 irq0", {31'd0, irq[0]}, 32'd1);
        chk("R9 irq1 masked", {31'd0, irq[1]}, 32'd0);
        rd(A_STAT1, v); chk("R9 stat1 masked", v, '0);
        gpio_in = '0;   // falling, not enabled
        repeat (4) @(negedge clk);
        wr(A_STAT0, 32'h0);
        rd(A_STAT0, v); chk("R10 zero write keeps", v, 32'h8);
        wr(A_STAT0, 32'h8);
        rd(A_STAT0, v); chk("R10 clear", v, '0);
        chk("R10 irq low", {31'd0, irq[0]}, 32'd0);

        // R8 / R10 low level on pin 5, line 1; clear loses to active level
        wr(A_RISE, '0);
        wr(A_LO, 32'h20);
        wr(A_MASK1, 32'h20);
        @(negedge clk);
        rd(A_STAT1, v); chk("R8 low level", v, 32'h20);
        wr(A_STAT1, 32'h20);
        rd(A_STAT1, v); chk("R10 event wins", v, 32'h20);
        gpio_in = 32'h20;
        repeat (4) @(negedge clk);
        wr(A_STAT1, 32'h20);
        rd(A_STAT1, v); chk("R8 level gone", v, '0);

        // R5 / R6 soft reset
        wr(A_DIR, 32'h0); wr(A_DOUT, 32'hA5A5_A5A5); wr(A_HI, 32'h20); wr(A_MASK0, 32'h20);
        @(negedge clk);
        rd(A_STAT0, v); chk("R8 high level", v, 32'h20);
        wr(A_CTRL, 32'h0);
        chk("R5 zero write no effect", gpio_out, 32'hA5A5_A5A5);
        rd(A_CTRL, v); chk("R5 ctrl after zero", v, 32'd2);
        wr(A_CTRL, 32'h1);
        rd(A_CTRL, v); chk("R6 done low 1", v, 32'd0);
        bus_wr = 1'b1; bus_addr = 4'(A_DOUT); bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk); bus_wr = 1'b0;
        rd(A_CTRL, v); chk("R6 done low 2", v, 32'd0);
        @(negedge clk); rd(A_CTRL, v); chk("R6 done low 3", v, 32'd0);
        @(negedge clk); rd(A_CTRL, v); chk("R6 done low 4", v, 32'd0);
        @(negedge clk); rd(A_CTRL, v); chk("R6 done high", v, 32'd2);
        chk("R6 write ignored", gpio_out, '0);
        chk("R5 drive", gpio_drive, '0);
        rd(A_DIR, v); chk("R5 dir", v, '1);
        rd(A_HI, v); chk("R5 hi", v, '0);
        rd(A_MASK0, v); chk("R5 mask", v, '0);
        rd(A_STAT0, v); chk("R5 stat", v, '0);
        chk("R5 irq", {30'd0, irq}, '0);

        // R7..R10 random two-value transitions
        for (int i = 0; i < 40; i++) begin
            logic [31:0] a, b, re, fe, he, le, m0, m1;
            a = $urandom; b = $urandom;
            re = $urandom; fe = $urandom;
            he = $urandom & $urandom & $urandom; le = $urandom & $urandom & $urandom;
            m0 = $urandom; m1 = $urandom;
            @(negedge clk); gpio_in = a;
            repeat (4) @(negedge clk);
            wr(A_RISE, re); wr(A_FALL, fe); wr(A_HI, he); wr(A_LO, le);
            wr(A_MASK0, m0); wr(A_MASK1, m1);
            wr(A_STAT0, '1); wr(A_STAT1, '1);
            gpio_in = b;
            repeat (4) @(negedge clk);
            rd(A_STAT0, s0); rd(A_STAT1, s1);
            chk("R7 R8 R9 stat0 rnd", s0, exp_stat(a, b, re, fe, he, le, m0));
            chk("R9 stat1 rnd", s1, exp_stat(a, b, re, fe, he, le, m1));
            chk("R9 irq rnd", {30'd0, irq},
                {30'd0, |exp_stat(a, b, re, fe, he, le, m1), |exp_stat(a, b, re, fe, he, le, m0)});
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule